// File: doc/BRIEF.md
# Strap-Configurable Buffered Host Bus Adapter

The adapter connects a host processor to a 16-bit internal space that holds both memory and registers. Each host access is framed by a one-cycle strobe. The adapter decodes the access and issues a one-cycle request on the internal bus. It then returns a one-cycle ready pulse, and read data travels with that pulse. In the wide mode every host access maps to one internal word access. In the narrow mode the host moves bytes on the low eight data lines. Two byte writes are merged into one internal word write. An internal word read is split into two bytes for the host.

Static strap inputs fit the adapter to the host's bus conventions. One strap sets the sense of the read/write line, one sets the sense of the byte-select line, and one sets which byte of a pair comes first. A pair that breaks protocol is dropped. This happens when a byte arrives out of order, when the memory/register select changes, or when the direction changes. A dropped pair produces an error pulse alongside ready, and the pair tracker returns to its start state.

The internal space answers reads in the same cycle as the request. Read data must be valid while `req_o` is high, and it is sampled at the end of that cycle.

Top module: `host_bus_adapter`

## Requirements
- R1: In wide mode, an access is a read when `rw_i` equals `rw_pol_i`, and a write otherwise.
- R2: In narrow mode, an access targets the upper byte when `bsel_i` differs from `bsel_pol_i`, and the lower byte when they are equal. In narrow mode `rw_i` high means read.
- R3: `order_i` high makes the upper byte first in every narrow pair, and low makes the lower byte first. `order_i` has no effect in wide mode.
- R4: `req_mem_o` follows `mem_sel_i` of the access, with 1 meaning memory and 0 meaning register.
- R5: Narrow mode is active only when `xparent_i` and `wide_i` are both low. Any other combination gives wide mode.
- R6: A narrow write issues no request on its first byte. On the second byte it issues one write of the assembled word, with the first byte placed in its own lane. The address is taken from the second byte.
- R7: The first byte of a narrow read issues an internal read and returns the selected byte on `host_rdata_o[7:0]`. The second byte issues no request and returns the other byte of the same word. The upper bits of `host_rdata_o` are zero in narrow mode.
- R8: A narrow byte that is not the expected one for the pair position issues no request, raises `err_o` with ready, and restarts the pair.
- R9: A change of `mem_sel_i` or of direction between the two bytes of a pair drops the pair. No request is issued, `err_o` pulses, and the next byte is treated as a first byte.
- R10: The cycle after a strobe is the request cycle, and `req_o` is high then if a request is due. `ready_o` pulses for exactly one cycle, the cycle after that. `host_rdata_o` is valid with ready and is zero for writes and for errors.
- R11: While reset is asserted, `req_o`, `ready_o`, `err_o` and `host_rdata_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle access strobe |
| rw_i | input | 1 | Read/write line |
| rw_pol_i | input | 1 | Read/write sense strap |
| bsel_i | input | 1 | Byte-select line |
| bsel_pol_i | input | 1 | Byte-select sense strap |
| order_i | input | 1 | Byte-order strap, 1 means upper byte first |
| wide_i | input | 1 | 16/8 mode input |
| xparent_i | input | 1 | Transparent/buffered input |
| mem_sel_i | input | 1 | 1 selects memory, 0 selects registers |
| addr_i | input | ADDR_W | Access address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data, valid with ready |
| ready_o | output | 1 | Access-complete pulse |
| err_o | output | 1 | Pair protocol error pulse |
| req_o | output | 1 | Internal request pulse |
| req_we_o | output | 1 | Internal write enable |
| req_mem_o | output | 1 | Internal memory/register select |
| req_addr_o | output | ADDR_W | Internal address |
| req_wdata_o | output | DATA_W | Internal write word |
| req_rdata_i | input | DATA_W | Internal read word, valid while req_o |

## Verification
A pair tracker stuck in the wrong position shows on the next narrow byte. A first byte would then issue a request, or a second byte would raise `err_o` instead of one. Both effects appear in the request cycle and the ready cycle of that byte, two cycles after the strobe. A stale or wrong read latch shows as a wrong second byte on `host_rdata_o`. Lane mistakes show as swapped bytes in `req_wdata_o` during the request cycle of the second write byte. Straps are swept across their values, so an inverted sense turns a write into a read, or the reverse, at the very next access.

// File: rtl/hba_pkg.sv
package hba_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_BUS, SRC_LATCH} rd_src_e;

  typedef struct packed {
    logic narrow;
    logic is_read;
    logic is_msb;
    logic first_msb;
  } acc_dec_t;
endpackage

// File: rtl/hba_decode.sv
module hba_decode
  import hba_pkg::*;
(
  input  logic     rw_i,
  input  logic     rw_pol_i,
  input  logic     bsel_i,
  input  logic     bsel_pol_i,
  input  logic     order_i,
  input  logic     wide_i,
  input  logic     xparent_i,
  output acc_dec_t dec_o
);
  always_comb begin
    dec_o.narrow    = !xparent_i && !wide_i;
    dec_o.is_read   = dec_o.narrow ? rw_i : (rw_i == rw_pol_i);
    dec_o.is_msb    = bsel_i ^ bsel_pol_i;
    dec_o.first_msb = order_i;
  end
endmodule

// File: rtl/hba_pair_ctl.sv
module hba_pair_ctl
  import hba_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  acc_dec_t          dec_i,
  input  logic              mem_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              issue_o,
  output logic              issue_we_o,
  output logic [DATA_W-1:0] word_o,
  output rd_src_e           src_o,
  output logic              err_o
);
  logic              half_q, half_rd_q, half_mem_q;
  logic [BYTE_W-1:0] stage_q;
  logic              ok;

  wire [BYTE_W-1:0] byte_in = wdata_i[BYTE_W-1:0];

  always_comb begin
    issue_o    = 1'b0;
    issue_we_o = 1'b0;
    src_o      = SRC_NONE;
    err_o      = 1'b0;
    ok         = 1'b0;
    word_o     = wdata_i;
    if (acc_i) begin
      if (!dec_i.narrow) begin
        issue_o    = 1'b1;
        issue_we_o = !dec_i.is_read;
        src_o      = dec_i.is_read ? SRC_BUS : SRC_NONE;
      end else if (!half_q) begin
        ok = (dec_i.is_msb == dec_i.first_msb);
        if (ok && dec_i.is_read) begin
          issue_o = 1'b1;
          src_o   = SRC_BUS;
        end
        err_o = !ok;
      end else begin
        ok = (dec_i.is_msb != dec_i.first_msb) &&
             (dec_i.is_read == half_rd_q) && (mem_i == half_mem_q);
        if (ok && !dec_i.is_read) begin
          issue_o    = 1'b1;
          issue_we_o = 1'b1;
          word_o     = dec_i.first_msb ? {stage_q, byte_in} : {byte_in, stage_q};
        end else if (ok) begin
          src_o = SRC_LATCH;
        end
        err_o = !ok;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q     <= 1'b0;
      half_rd_q  <= 1'b0;
      half_mem_q <= 1'b0;
      stage_q    <= '0;
    end else if (acc_i) begin
      if (dec_i.narrow && !half_q && ok) begin
        half_q     <= 1'b1;
        half_rd_q  <= dec_i.is_read;
        half_mem_q <= mem_i;
        stage_q    <= byte_in;
      end else begin
        half_q <= 1'b0;
      end
    end
  end

  // R5
  wide_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !dec_i.narrow) |=> !half_q);

  // R6
  narrow_wr_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_we_o && dec_i.narrow) |-> half_q);
endmodule

// File: rtl/host_bus_adapter.sv
module host_bus_adapter
  import hba_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int BYTE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              rw_i,
  input  logic              rw_pol_i,
  input  logic              bsel_i,
  input  logic              bsel_pol_i,
  input  logic              order_i,
  input  logic              wide_i,
  input  logic              xparent_i,
  input  logic              mem_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              ready_o,
  output logic              err_o,
  output logic              req_o,
  output logic              req_we_o,
  output logic              req_mem_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic [DATA_W-1:0] req_rdata_i
);
  acc_dec_t          dec;
  logic              issue, issue_we, perr;
  logic [DATA_W-1:0] word;
  rd_src_e           src;

  logic              p_valid, p_err, p_narrow, p_msb;
  rd_src_e           p_src;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] rdata_d;

  hba_decode u_dec (
    .rw_i, .rw_pol_i, .bsel_i, .bsel_pol_i, .order_i, .wide_i, .xparent_i,
    .dec_o(dec)
  );

  hba_pair_ctl #(.DATA_W(DATA_W)) u_pair (
    .clk_i, .rst_ni,
    .acc_i     (strobe_i),
    .dec_i     (dec),
    .mem_i     (mem_sel_i),
    .wdata_i   (host_wdata_i),
    .issue_o   (issue),
    .issue_we_o(issue_we),
    .word_o    (word),
    .src_o     (src),
    .err_o     (perr)
  );

  // request stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o       <= 1'b0;
      req_we_o    <= 1'b0;
      req_mem_o   <= 1'b0;
      req_addr_o  <= '0;
      req_wdata_o <= '0;
      p_valid     <= 1'b0;
      p_err       <= 1'b0;
      p_narrow    <= 1'b0;
      p_msb       <= 1'b0;
      p_src       <= SRC_NONE;
    end else begin
      req_o    <= issue;
      p_valid  <= strobe_i;
      p_err    <= perr;
      p_src    <= src;
      p_narrow <= dec.narrow;
      p_msb    <= dec.is_msb;
      if (issue) begin
        req_we_o    <= issue_we;
        req_mem_o   <= mem_sel_i;
        req_addr_o  <= addr_i;
        req_wdata_o <= word;
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    unique case (p_src)
      SRC_BUS: begin
        if (!p_narrow) rdata_d = req_rdata_i;
        else rdata_d[BYTE_W-1:0] = p_msb ? req_rdata_i[DATA_W-1:BYTE_W]
                                         : req_rdata_i[BYTE_W-1:0];
      end
      SRC_LATCH: rdata_d[BYTE_W-1:0] = p_msb ? word_q[DATA_W-1:BYTE_W]
                                             : word_q[BYTE_W-1:0];
      default: rdata_d = '0;
    endcase
  end

  // response stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o      <= 1'b0;
      err_o        <= 1'b0;
      host_rdata_o <= '0;
      word_q       <= '0;
    end else begin
      ready_o      <= p_valid;
      err_o        <= p_valid && p_err;
      host_rdata_o <= p_valid ? rdata_d : '0;
      if (p_valid && p_src == SRC_BUS) word_q <= req_rdata_i;
    end
  end

  // R10
  ready_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> ##1 ready_o);

  // R10
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(strobe_i));

  // R8
  err_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(req_o));

  // R10
  err_with_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o);
endmodule

// File: tb/sim_host_bus_adapter.sv
`timescale 1ns/1ps
module sim_host_bus_adapter;
  localparam int AW = 8;
  localparam int DW = 16;

  typedef struct packed {
    logic [3:0]  rq;
    logic        wide;
    logic        rwp;
    logic        bsp;
    logic        ord;
    logic        rw;
    logic        bsel;
    logic        mem;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic        e_req;
    logic        e_we;
    logic        e_mem;
    logic [15:0] e_wd;
    logic [15:0] e_rd;
    logic        e_err;
  } tvec_t;

  localparam int NV = 22;
  // rq wide rwp bsp ord rw bsel mem addr wd | req we mem wd rd err
  localparam tvec_t VEC [NV] = '{
    '{4'd1, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,8'h12,16'h0000, 1'b1,1'b0,1'b1,16'h0000,16'hED12,1'b0}, // R1 read
    '{4'd4, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h34,16'hBEEF, 1'b1,1'b1,1'b0,16'hBEEF,16'h0000,1'b0}, // R1 R4 write reg
    '{4'd1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h56,16'h0000, 1'b1,1'b0,1'b0,16'h0000,16'hA956,1'b0}, // R1 inverted read
    '{4'd4, 1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,8'h57,16'h1234, 1'b1,1'b1,1'b1,16'h1234,16'h0000,1'b0}, // R1 R4 write mem
    '{4'd3, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'h56,16'h0000, 1'b1,1'b0,1'b0,16'h0000,16'hA956,1'b0}, // R3 order ignored wide
    '{4'd6, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,8'h10,16'h00AB, 1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0}, // R6 first msb
    '{4'd6, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h11,16'h00CD, 1'b1,1'b1,1'b1,16'hABCD,16'h0000,1'b0}, // R6 second lsb
    '{4'd2, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h10,16'h0011, 1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0}, // R2 R3 lsb first
    '{4'd3, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h10,16'h0022, 1'b1,1'b1,1'b1,16'h2211,16'h0000,1'b0}, // R3 assembled
    '{4'd7, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h20,16'h0000, 1'b1,1'b0,1'b0,16'h0000,16'h00DF,1'b0}, // R7 read msb
    '{4'd7, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,8'h20,16'h0000, 1'b0,1'b0,1'b0,16'h0000,16'h0020,1'b0}, // R7 latch lsb
    '{4'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,8'h3C,16'h0000, 1'b1,1'b0,1'b1,16'h0000,16'h003C,1'b0}, // R2 read lsb
    '{4'd7, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,8'h3C,16'h0000, 1'b0,1'b0,1'b0,16'h0000,16'h00C3,1'b0}, // R7 latch msb
    '{4'd8, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h01,16'h0055, 1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b1}, // R8 wrong first
    '{4'd8, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,8'h01,16'h0077, 1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0}, // R8 restart
    '{4'd8, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h02,16'h0088, 1'b1,1'b1,1'b1,16'h7788,16'h0000,1'b0}, // R8 pair ok
    '{4'd9, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,8'h03,16'h0099, 1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0}, // R9 first
    '{4'd9, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h03,16'h00AA, 1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b1}, // R9 sel change
    '{4'd9, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,8'h04,16'h0066, 1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0}, // R9 new first
    '{4'd9, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h05,16'h0044, 1'b1,1'b1,1'b0,16'h6644,16'h0000,1'b0}, // R9 pair ok
    '{4'd7, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'h40,16'h0000, 1'b1,1'b0,1'b1,16'h0000,16'h00BF,1'b0}, // R7 read first
    '{4'd9, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h40,16'h0011, 1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b1}  // R9 dir change
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 0, rw = 0, rw_pol = 0, bsel = 0, bsel_pol = 0, order = 0;
  logic wide = 0, xparent = 0, mem_sel = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, req_wdata, req_rdata;
  logic ready, err, req, req_we, req_mem;
  logic [AW-1:0] req_addr;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign req_rdata = (req && !req_we) ? {~req_addr, req_addr} : '0;

  host_bus_adapter #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .rw_i(rw), .rw_pol_i(rw_pol),
    .bsel_i(bsel), .bsel_pol_i(bsel_pol), .order_i(order), .wide_i(wide),
    .xparent_i(xparent), .mem_sel_i(mem_sel), .addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .ready_o(ready), .err_o(err), .req_o(req),
    .req_we_o(req_we), .req_mem_o(req_mem), .req_addr_o(req_addr),
    .req_wdata_o(req_wdata), .req_rdata_i(req_rdata)
  );

  task automatic chk(input bit ok, input string what, input int rq,
                     input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input tvec_t v, input logic xp);
    @(negedge clk);
    wide = v.wide; xparent = xp; rw_pol = v.rwp; bsel_pol = v.bsp; order = v.ord;
    rw = v.rw; bsel = v.bsel; mem_sel = v.mem; addr = v.addr; wdata = v.wd;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    chk(req == v.e_req, "req", v.rq, 16'(req), 16'(v.e_req));
    chk(!ready, "ready early (R10)", 10, 16'(ready), 16'h0);
    if (v.e_req) begin
      chk(req_we == v.e_we, "we", v.rq, 16'(req_we), 16'(v.e_we));
      chk(req_mem == v.e_mem, "mem (R4)", 4, 16'(req_mem), 16'(v.e_mem));
      if (v.e_we) chk(req_wdata == v.e_wd, "wdata", v.rq, req_wdata, v.e_wd);
    end
    @(negedge clk);
    chk(ready, "ready (R10)", 10, 16'(ready), 16'h1);
    chk(!req, "req one cycle (R10)", 10, 16'(req), 16'h0);
    chk(err == v.e_err, "err", v.rq, 16'(err), 16'(v.e_err));
    chk(rdata == v.e_rd, "rdata", v.rq, rdata, v.e_rd);
    @(negedge clk);
    chk(!ready, "ready one cycle (R10)", 10, 16'(ready), 16'h0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk(!req && !ready && !err && rdata == '0, "reset outputs (R11)", 11,
        {ready, err, req, 13'h0}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R5: transparent high with 16/8 low is wide; a single write goes out at once
    run_vec('{4'd5, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h70,16'hC0DE,
              1'b1,1'b1,1'b1,16'hC0DE,16'h0000,1'b0}, 1'b1);
    // R5: both high is wide too
    run_vec('{4'd5, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h71,16'h0000,
              1'b1,1'b0,1'b0,16'h0000,16'h8E71,1'b0}, 1'b1);
    // R3: a half pair is dropped by a wide access; narrow restarts as first byte
    run_vec('{4'd6, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,8'h72,16'h0012,
              1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0}, 1'b0);
    run_vec('{4'd5, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,8'h73,16'h5A5A,
              1'b1,1'b1,1'b1,16'h5A5A,16'h0000,1'b0}, 1'b0);
    run_vec('{4'd8, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h74,16'h0034,
              1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b1}, 1'b0);

    // R11: reset mid pair clears the tracker
    run_vec('{4'd6, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,8'h75,16'h00EE,
              1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b0}, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ready && !req, "outputs in reset (R11)", 11, {ready, req, 14'h0}, 16'h0);
    rst_n = 1'b1;
    run_vec('{4'd11, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,8'h76,16'h00FF,
              1'b0,1'b0,1'b0,16'h0000,16'h0000,1'b1}, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule